// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen single-cycle event pulses, latches each into a per-channel pending flag and resolves which flag wins. It signals the host on an active-low request line. The host then runs an acknowledge cycle, and the block answers it with an 8-bit vector. The vector's upper nibble comes from a software-programmed base and its lower nibble is the number of the winning channel. Channel 15 has the highest priority and channel 0 the lowest.

Every channel carries four state bits: enable, pending, mask and in-service. Software reaches them through a byte-wide register bus. For each kind of state, the "A" byte holds channels 15..8 and the "B" byte holds channels 7..0. Bit 3 of the vector base register picks the end-of-interrupt style. In automatic mode an acknowledge simply retires the pending flag. In software mode an acknowledge also marks the channel in service, and that blocks equal and lower priorities until software clears the in-service bit.

Register addresses: 0 enable A, 1 enable B, 2 pending A, 3 pending B, 4 in-service A, 5 in-service B, 6 mask A, 7 mask B, 8 vector base. Any other address reads as zero.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all enable, pending, in-service, mask and vector-base bits are 0, `irq_no` is high, and an acknowledge returns `vec_valid_o` low.
- R2: A pulse on `src_i[n]` while enable bit n is 0 leaves pending bit n at 0 and `irq_no` high.
- R3: A pulse on `src_i[n]` while enable bit n is 1 sets pending bit n on the next clock edge, and `irq_no` falls if mask bit n is 1 and nothing at or above n is in service.
- R4: A pending channel whose mask bit is 0 stays visible in the pending register but does not pull `irq_no` low. Setting the mask bit afterwards raises the request.
- R5: When several unmasked channels are pending, the acknowledge selects the highest-numbered one. Bit 7 of byte A (channel 15) ranks highest.
- R6: During an acknowledge with a request active, `vec_valid_o` is 1 and `vec_o` equals {base[7:4], winning channel number}.
- R7: With base bit 3 at 0 (automatic mode), an acknowledge clears the winner's pending bit and leaves its in-service bit at 0.
- R8: With base bit 3 at 1 (software mode), an acknowledge clears the winner's pending bit and sets its in-service bit. While channel s is in service, only pending unmasked channels numbered above s can pull `irq_no` low.
- R9: Writing the pending or in-service byte clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R10: Writing 0 to an enable bit also clears that channel's pending bit.
- R11: An event on a channel in the same cycle as that channel's acknowledge leaves its pending bit set.
- R12: `rdata_o` shows the addressed register only while `rd_i` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | One-cycle event pulses, bit n is channel n |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Register read data |
| iack_i | input | 1 | Interrupt acknowledge, one cycle |
| vec_o | output | 8 | Vector for the current winner |
| vec_valid_o | output | 1 | Acknowledge accepted, vector valid |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions check several properties on every cycle. A request never stands without a pending unmasked channel. An accepted vector always names the top pending unmasked channel and carries the programmed base nibble. No in-service channel sits at or above a requesting winner. On each channel, events, acknowledges, disables and clearing writes have their defined next-cycle effect. Some behaviour only the bench's scenarios can show: the ordering of every pair of channels, the gating between every in-service/pending pair in software mode, the read-back encoding of each register byte, and the fact that an event on a disabled channel leaves no trace at the ports.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned CH_N   = 16;
  localparam int unsigned ID_W   = $clog2(CH_N);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BANK_N = CH_N / BYTE_W;
  localparam int unsigned ADDR_W = 4;
  // each register kind occupies BANK_N consecutive bytes, high channels first
  localparam int unsigned ADDR_EN    = 0;
  localparam int unsigned ADDR_PEND  = ADDR_EN + BANK_N;
  localparam int unsigned ADDR_INSVC = ADDR_PEND + BANK_N;
  localparam int unsigned ADDR_MASK  = ADDR_INSVC + BANK_N;
  localparam int unsigned ADDR_VEC   = ADDR_MASK + BANK_N;
  localparam int unsigned MODE_BIT   = 3;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N   = 16,
  parameter int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] id_o
);
  // later (higher) index overrides: highest set bit wins
  always_comb begin
    id_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vic_chan.sv
module vic_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic en_i,
  input  logic en_clr_i,
  input  logic pend_wr_i,
  input  logic pend_wbit_i,
  input  logic insvc_wr_i,
  input  logic insvc_wbit_i,
  input  logic ack_i,
  input  logic sw_mode_i,
  output logic pend_o,
  output logic insvc_o
);
  logic pend_q, pend_d, insvc_q, insvc_d, evt;

  assign evt = src_i && en_i && !en_clr_i;

  always_comb begin
    pend_d = pend_q;
    if (pend_wr_i && !pend_wbit_i) pend_d = 1'b0;
    if (en_clr_i) pend_d = 1'b0;
    if (ack_i) pend_d = 1'b0;
    if (evt) pend_d = 1'b1;  // fresh event outranks every clear
    insvc_d = insvc_q;
    if (insvc_wr_i && !insvc_wbit_i) insvc_d = 1'b0;
    if (ack_i && sw_mode_i) insvc_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = insvc_q;

  assert_drop_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i && !en_i && !pend_q) |=> !pend_o);
  assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i && en_i && !en_clr_i) |=> pend_o);
  assert_auto_no_insvc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !sw_mode_i && !insvc_q) |=> !insvc_o);
  assert_sw_sets_insvc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sw_mode_i) |=> insvc_o);
  assert_pend_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_wr_i && !pend_wbit_i && !src_i) |=> !pend_o);
  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !pend_o);
  assert_ack_event_keeps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && src_i && en_i && !en_clr_i) |=> pend_o);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CH_N-1:0]     src_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic                iack_i,
  output logic [BYTE_W-1:0]   vec_o,
  output logic                vec_valid_o,
  output logic                irq_no
);
  logic [CH_N-1:0]   en_q, mask_q, pend, insvc, ack_c, cand;
  logic [BYTE_W-1:0] vbase_q, rd_mux;
  logic              cand_any, svc_any, req, sw_mode;
  logic [ID_W-1:0]   win_id, svc_id;

  assign sw_mode = vbase_q[MODE_BIT];

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    localparam int unsigned OFS = BANK_N - 1 - b;
    logic              en_we, pend_we, insvc_we, mask_we;
    logic [BYTE_W-1:0] en_b_q, mask_b_q;

    assign en_we    = wr_i && (addr_i == ADDR_W'(ADDR_EN + OFS));
    assign pend_we  = wr_i && (addr_i == ADDR_W'(ADDR_PEND + OFS));
    assign insvc_we = wr_i && (addr_i == ADDR_W'(ADDR_INSVC + OFS));
    assign mask_we  = wr_i && (addr_i == ADDR_W'(ADDR_MASK + OFS));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_b_q   <= '0;
        mask_b_q <= '0;
      end else begin
        if (en_we)   en_b_q   <= wdata_i;
        if (mask_we) mask_b_q <= wdata_i;
      end
    end

    assign en_q[b*BYTE_W +: BYTE_W]   = en_b_q;
    assign mask_q[b*BYTE_W +: BYTE_W] = mask_b_q;

    for (genvar k = 0; k < BYTE_W; k++) begin : g_ch
      localparam int unsigned C = b*BYTE_W + k;
      assign ack_c[C] = vec_valid_o && (win_id == ID_W'(C));
      vic_chan u_chan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .src_i        (src_i[C]),
        .en_i         (en_b_q[k]),
        .en_clr_i     (en_we && !wdata_i[k]),
        .pend_wr_i    (pend_we),
        .pend_wbit_i  (wdata_i[k]),
        .insvc_wr_i   (insvc_we),
        .insvc_wbit_i (wdata_i[k]),
        .ack_i        (ack_c[C]),
        .sw_mode_i    (sw_mode),
        .pend_o       (pend[C]),
        .insvc_o      (insvc[C])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vbase_q <= '0;
    else if (wr_i && addr_i == ADDR_W'(ADDR_VEC)) vbase_q <= wdata_i;
  end

  assign cand = pend & mask_q;

  vic_prio_enc #(.N(CH_N), .IDW(ID_W)) u_enc_cand (
    .req_i (cand),
    .any_o (cand_any),
    .id_o  (win_id)
  );

  vic_prio_enc #(.N(CH_N), .IDW(ID_W)) u_enc_svc (
    .req_i (insvc),
    .any_o (svc_any),
    .id_o  (svc_id)
  );

  // winner must outrank the highest channel in service
  assign req         = cand_any && (!svc_any || win_id > svc_id);
  assign irq_no      = !req;
  assign vec_valid_o = iack_i && req;
  assign vec_o       = {vbase_q[BYTE_W-1:BYTE_W-4], win_id};

  always_comb begin
    rd_mux = '0;
    for (int unsigned b = 0; b < BANK_N; b++) begin
      if (addr_i == ADDR_W'(ADDR_EN + BANK_N - 1 - b))    rd_mux = en_q[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(ADDR_PEND + BANK_N - 1 - b))  rd_mux = pend[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(ADDR_INSVC + BANK_N - 1 - b)) rd_mux = insvc[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(ADDR_MASK + BANK_N - 1 - b))  rd_mux = mask_q[b*BYTE_W +: BYTE_W];
    end
    if (addr_i == ADDR_W'(ADDR_VEC)) rd_mux = vbase_q;
  end

  assign rdata_o = rd_i ? rd_mux : '0;

  assert_req_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (|(pend & mask_q)));
  assert_vec_highest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((pend & mask_q) >> vec_o[ID_W-1:0]) == CH_N'(1));
  assert_vec_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[BYTE_W-1:BYTE_W-4] == vbase_q[BYTE_W-1:BYTE_W-4]));
  assert_insvc_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ((insvc >> vec_o[ID_W-1:0]) == '0));
  assert_ack_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !irq_no);
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_EN = 0, A_PEND = 2, A_INSVC = 4, A_MASK = 6, A_VEC = 8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] src = '0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, vec;
  logic        wr = 1'b0, rd = 1'b0, iack = 1'b0, vec_valid, irq_no;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .iack_i(iack), .vec_o(vec),
    .vec_valid_o(vec_valid), .irq_no(irq_no)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bit_of(int c);
    return 16'(1) << c;
  endfunction

  task automatic wr8(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic wr16(logic [3:0] base, logic [15:0] v);
    wr8(base, v[15:8]);
    wr8(base + 4'd1, v[7:0]);
  endtask

  task automatic rd8(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1;
    d = rdata; rd = 1'b0;
  endtask

  task automatic rd16(logic [3:0] base, output logic [15:0] v);
    logic [7:0] hi, lo;
    rd8(base, hi);
    rd8(base + 4'd1, lo);
    v = {hi, lo};
  endtask

  task automatic pulse(logic [15:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = '0; #1;
  endtask

  task automatic ack(output logic [7:0] v, output logic ok);
    @(negedge clk); iack = 1'b1; #1;
    v = vec; ok = vec_valid;
    @(negedge clk); iack = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v16;
    logic [7:0]  v8, vv;
    logic        ok;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;

    // R1 reset state
    chk("R1 irq_no", int'(irq_no), 1);
    for (int a = 0; a < 9; a++) begin
      rd8(4'(a), v8);
      chk("R1 reg zero", int'(v8), 0);
    end
    ack(vv, ok);
    chk("R1 no vector", int'(ok), 0);

    // R12 read strobe gating and byte placement
    wr8(A_EN, 8'h5a);
    @(negedge clk); addr = A_EN; rd = 1'b0; #1;
    chk("R12 rdata idle", int'(rdata), 0);
    rd8(A_EN, v8);
    chk("R12 rdata read", int'(v8), 'h5a);
    wr8(A_VEC, 8'hc3);
    rd8(A_VEC, v8);
    chk("R12 vec read", int'(v8), 'hc3);
    rd8(4'd12, v8);
    chk("R12 unused addr", int'(v8), 0);

    // R2 disabled channel drops events
    wr16(A_MASK, 16'hffff);
    for (int c = 0; c < 16; c++) begin
      wr16(A_EN, ~bit_of(c));
      pulse(bit_of(c));
      rd16(A_PEND, v16);
      chk("R2 no pending", int'(v16), 0);
      chk("R2 irq idle", int'(irq_no), 1);
    end

    // R3 R6 R7 single channel, automatic mode
    wr8(A_VEC, 8'ha0);
    wr16(A_EN, 16'hffff);
    for (int c = 0; c < 16; c++) begin
      pulse(bit_of(c));
      rd16(A_PEND, v16);
      chk("R3 pending set", int'(v16), int'(bit_of(c)));
      chk("R3 irq low", int'(irq_no), 0);
      ack(vv, ok);
      chk("R6 valid", int'(ok), 1);
      chk("R6 vector", int'(vv), 'ha0 + c);
      rd16(A_PEND, v16);
      chk("R7 pending cleared", int'(v16), 0);
      rd16(A_INSVC, v16);
      chk("R7 insvc clear", int'(v16), 0);
      chk("R7 irq released", int'(irq_no), 1);
    end

    // R4 masking, R9 pending write semantics
    for (int c = 0; c < 16; c++) begin
      wr16(A_MASK, ~bit_of(c));
      pulse(bit_of(c));
      rd16(A_PEND, v16);
      chk("R4 masked recorded", int'(v16), int'(bit_of(c)));
      chk("R4 masked no irq", int'(irq_no), 1);
      wr16(A_MASK, 16'hffff);
      chk("R4 unmask raises", int'(irq_no), 0);
      wr16(A_PEND, 16'hffff);
      rd16(A_PEND, v16);
      chk("R9 ones keep pending", int'(v16), int'(bit_of(c)));
      wr16(A_PEND, ~bit_of(c));
      rd16(A_PEND, v16);
      chk("R9 zero clears pending", int'(v16), 0);
      chk("R9 irq released", int'(irq_no), 1);
    end

    // R5 every pair, highest wins
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        pulse(bit_of(a) | bit_of(b));
        ack(vv, ok);
        chk("R5 first winner", int'(vv), 'ha0 + b);
        ack(vv, ok);
        chk("R5 second winner", int'(vv), 'ha0 + a);
        chk("R5 drained", int'(irq_no), 1);
      end
    end

    // R8 software mode nesting over every ordered pair
    wr8(A_VEC, 8'h58);
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        if (p == s) continue;
        pulse(bit_of(s));
        ack(vv, ok);
        chk("R8 vec s", int'(vv), 'h50 + s);
        rd16(A_INSVC, v16);
        chk("R8 insvc set", int'(v16), int'(bit_of(s)));
        pulse(bit_of(p));
        chk("R8 nesting gate", int'(irq_no), (p > s) ? 0 : 1);
        if (p > s) begin
          ack(vv, ok);
          chk("R8 nested vec", int'(vv), 'h50 + p);
          wr16(A_INSVC, 16'hffff);
          rd16(A_INSVC, v16);
          chk("R9 ones keep insvc", int'(v16), int'(bit_of(s) | bit_of(p)));
          wr16(A_INSVC, 16'h0000);
        end else begin
          wr16(A_INSVC, 16'h0000);
          chk("R9 insvc clear unblocks", int'(irq_no), 0);
          ack(vv, ok);
          chk("R8 late vec", int'(vv), 'h50 + p);
          wr16(A_INSVC, 16'h0000);
        end
        rd16(A_INSVC, v16);
        chk("R9 insvc empty", int'(v16), 0);
        rd16(A_PEND, v16);
        chk("R8 pending empty", int'(v16), 0);
      end
    end

    // R10 disable clears pending
    wr8(A_VEC, 8'ha0);
    wr16(A_MASK, 16'h0000);
    for (int c = 0; c < 16; c++) begin
      wr16(A_EN, 16'hffff);
      pulse(bit_of(c));
      wr16(A_EN, ~bit_of(c));
      wr16(A_EN, 16'hffff);
      rd16(A_PEND, v16);
      chk("R10 disable clears", int'(v16), 0);
    end

    // R11 event coinciding with its own acknowledge
    wr16(A_MASK, 16'hffff);
    for (int c = 0; c < 16; c++) begin
      pulse(bit_of(c));
      @(negedge clk); iack = 1'b1; src = bit_of(c); #1;
      vv = vec; ok = vec_valid;
      @(negedge clk); iack = 1'b0; src = '0; #1;
      chk("R11 vec", int'(vv), 'ha0 + c);
      rd16(A_PEND, v16);
      chk("R11 pending kept", int'(v16), int'(bit_of(c)));
      ack(vv, ok);
      rd16(A_PEND, v16);
      chk("R11 drained", int'(v16), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule